// File: doc/BRIEF.md
# Address-Filtering Shared-Bus SPI Responder

This block is one responder on a four-wire SPI bus where every device shares chip select, clock and both data lines. Because chip select does not pick a device, the block wakes on each chip-select falling edge, captures the whole request, and keeps only requests whose destination matches its own address under a mask byte. Everything else is dropped, and any reply obligation it already holds stays as it was.

The exchange is a ping: an addressed ping request makes the responder owe a reply. A later addressed poll grants it the bus, and in the next session it drives a four-byte acknowledge. The first byte is the count of bytes that follow it. The acknowledge also carries a flag telling the controller whether local data is waiting. The data-out line is driven only during that acknowledge session and is released (output enable low) at all other times. All bus inputs are oversampled by the system clock.

Top module: `shared_spi_slave`

## Requirements
- R1: After reset, `somi_oe` is low and the block owes no reply, so a following poll session produces no acknowledge.
- R2: A request is exactly 24 bits in SPI mode 0, sent MSB first, with MOSI sampled on rising SCLK. Its three bytes are the destination address, the mask and the command.
- R3: A request is addressed to the block when `(dest ^ own_addr) & mask` is zero. A mask of 0xFF demands an exact match, and a mask of 0x00 accepts any destination.
- R4: A request that is not addressed to the block is discarded, and the block keeps whatever reply state it had before the session.
- R5: An addressed ping (command 0x01) makes the block owe a reply. An addressed poll (command 0x02) grants the bus only while a reply is owed. A poll with no reply owed, or any other command, leaves the state unchanged.
- R6: The session after a grant is an acknowledge. The block shifts out 0x03, then 0x06, then `own_addr`, then a flag byte with `has_data` (captured at the chip-select fall) in bit 0, and zeros after that. The first bit is valid before the first rising SCLK, and each later bit changes on falling SCLK.
- R7: `somi_oe` is high only during the acknowledge session and is low during every request session.
- R8: A chip-select rise ends every session. After an acknowledge the block owes nothing. A request cut short or overlong (not exactly 24 bits) is aborted, and the block returns to its state from before the session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr | input | 8 | Address of this responder |
| has_data | input | 1 | Local data waiting, reported in the acknowledge |
| cs_n | input | 1 | Shared chip select, active low |
| sclk | input | 1 | Bus clock from the controller |
| mosi | input | 1 | Controller-to-responder data |
| somi | output | 1 | Responder-to-controller data |
| somi_oe | output | 1 | Output enable for `somi` |

## Verification
The internal reply state cannot be seen directly. It shows only in the session that follows a poll: an acknowledge appears there or it does not. A wrongly kept or wrongly dropped reply obligation therefore shows up at most two sessions after the request that caused it. Errors in the shift path corrupt specific bytes of the acknowledge. A wrong enable appears within a few clocks of a chip-select edge, as `somi_oe` rising during a request session or failing to fall after a session ends.

// File: rtl/shared_spi_slave.sv
module shared_spi_slave #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] own_addr,
  input  logic          has_data,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          mosi,
  output logic          somi,
  output logic          somi_oe
);
  localparam int PKT_BITS = 3 * AW;
  localparam int ACK_BITS = 4 * AW;
  localparam int CW = $clog2(PKT_BITS + 2);
  localparam logic [CW-1:0] CNT_FULL = CW'(PKT_BITS);
  localparam logic [CW-1:0] CNT_MAX  = CW'(PKT_BITS + 1);
  localparam logic [AW-1:0] CMD_PING = AW'(1);
  localparam logic [AW-1:0] CMD_POLL = AW'(2);
  localparam logic [AW-1:0] CMD_ACK  = AW'(6);
  localparam logic [AW-1:0] RES_LEN  = AW'(3);

  typedef enum logic [2:0] {IDLE, RECV, PEND, GRANT, SEND} st_t;

  st_t st, ret;
  logic [2:0] cs_sr, sck_sr;
  logic [1:0] mo_sr;
  logic [CW-1:0] cnt;
  logic [PKT_BITS-1:0] rx;
  logic [ACK_BITS-1:0] tx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_sr  <= '1;
      sck_sr <= '0;
      mo_sr  <= '0;
    end else begin
      cs_sr  <= {cs_sr[1:0], cs_n};
      sck_sr <= {sck_sr[1:0], sclk};
      mo_sr  <= {mo_sr[0], mosi};
    end

  wire cs_fall  = cs_sr[2] & ~cs_sr[1];
  wire cs_rise  = ~cs_sr[2] & cs_sr[1];
  wire sck_rise = ~sck_sr[2] & sck_sr[1];
  wire sck_fall = sck_sr[2] & ~sck_sr[1];

  wire [AW-1:0] f_dest = rx[3*AW-1:2*AW];
  wire [AW-1:0] f_mask = rx[2*AW-1:AW];
  wire [AW-1:0] f_cmd  = rx[AW-1:0];
  wire hit = (cnt == CNT_FULL) && (((f_dest ^ own_addr) & f_mask) == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= IDLE;
      ret <= IDLE;
      cnt <= '0;
      rx  <= '0;
      tx  <= '0;
    end else begin
      case (st)
        IDLE, PEND:
          if (cs_fall) begin
            ret <= st;
            st  <= RECV;
            cnt <= '0;
          end
        GRANT:
          if (cs_fall) begin
            st <= SEND;
            tx <= {RES_LEN, CMD_ACK, own_addr, {(AW-1){1'b0}}, has_data};
          end
        RECV:
          if (cs_rise) begin
            if (hit && f_cmd == CMD_PING)                     st <= PEND;
            else if (hit && f_cmd == CMD_POLL && ret == PEND) st <= GRANT;
            else                                              st <= ret;
          end else if (sck_rise) begin
            if (cnt < CNT_FULL) rx <= {rx[PKT_BITS-2:0], mo_sr[1]};
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
          end
        SEND:
          if (cs_rise) st <= IDLE;
          else if (sck_fall) tx <= {tx[ACK_BITS-2:0], 1'b0};
        default: st <= IDLE;
      endcase
    end

  assign somi_oe = (st == SEND);
  assign somi    = somi_oe & tx[ACK_BITS-1];

  // R7
  oe_needs_cs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(somi_oe) |-> $past(cs_fall));
  // R8
  oe_drops_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (somi_oe && cs_rise) |=> !somi_oe);
  // R8
  ack_ends_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SEND && cs_rise) |=> st == IDLE);
  // R4
  miss_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RECV && cs_rise && !hit) |=> st == $past(ret));
  // R6
  ack_leads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(somi_oe) |-> !somi);
  // R2
  wake_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && cs_fall) |=> st == RECV);
endmodule

// File: tb/shared_spi_slave_bench.sv
module shared_spi_slave_bench;
  logic clk = 0, rst_n = 0;
  logic [7:0] own_addr = 8'hA5;
  logic has_data = 0, cs_n = 1, sclk = 0, mosi = 0;
  logic somi, somi_oe;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  shared_spi_slave u_shared_spi_slave (
    .clk(clk), .rst_n(rst_n), .own_addr(own_addr), .has_data(has_data),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .somi(somi), .somi_oe(somi_oe));

  localparam logic [16:0] TBL [8] = '{
    {8'hA5, 8'hFF, 1'b1}, {8'hA4, 8'hFF, 1'b0}, {8'hA0, 8'hF0, 1'b1},
    {8'hB5, 8'hF0, 1'b0}, {8'h00, 8'h00, 1'b1}, {8'h25, 8'h7F, 1'b1},
    {8'h25, 8'hFF, 1'b0}, {8'h35, 8'h0F, 1'b1}};

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic session(input logic [63:0] txd, input int nbits,
                         output logic [63:0] rxd, output logic oe_seen);
    rxd = '0; oe_seen = 0;
    @(negedge clk) cs_n = 0;
    repeat (10) @(negedge clk) oe_seen |= somi_oe;
    for (int i = 0; i < nbits; i++) begin
      mosi = txd[63-i];
      repeat (8) @(negedge clk) oe_seen |= somi_oe;
      rxd = {rxd[62:0], somi};
      sclk = 1;
      repeat (8) @(negedge clk) oe_seen |= somi_oe;
      sclk = 0;
    end
    repeat (6) @(negedge clk) oe_seen |= somi_oe;
    cs_n = 1;
    repeat (12) @(negedge clk);
  endtask

  function automatic logic [63:0] req(input logic [7:0] d, m, c);
    return {d, m, c, 40'h0};
  endfunction

  function automatic logic [63:0] ack(input logic [7:0] a, input logic f);
    return {24'h0, 8'h03, 8'h06, a, 7'h0, f, 8'h00};
  endfunction

  task automatic send(input logic [7:0] d, m, c, input int nb, input string tag);
    logic [63:0] r; logic oe;
    session(req(d, m, c), nb, r, oe);
    chk(!oe, tag, {63'h0, oe}, 64'h0);
  endtask

  task automatic expect_ack(input logic yes, input string tag);
    logic [63:0] r; logic oe;
    session('0, 40, r, oe);
    if (yes) chk(oe && r == ack(own_addr, has_data), tag, r, ack(own_addr, has_data));
    else     chk(!oe, tag, {63'h0, oe}, 64'h0);
    chk(!somi_oe, "R8 oe released after session", {63'h0, somi_oe}, 64'h0);
  endtask

  task automatic run;
    repeat (5) @(negedge clk);
    chk(!somi_oe, "R1 reset oe", {63'h0, somi_oe}, 64'h0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    send(8'hA5, 8'hFF, 8'h02, 24, "R7 poll rx no drive");
    expect_ack(0, "R1 no reply owed after reset");
    for (int i = 0; i < 8; i++) begin
      has_data = i[0];
      send(TBL[i][16:9], TBL[i][8:1], 8'h01, 24, "R7 ping rx no drive");
      send(8'hA5, 8'hFF, 8'h02, 24, "R7 poll rx no drive");
      expect_ack(TBL[i][0], $sformatf("R3 R6 table entry %0d", i));
    end
    has_data = 1;
    send(8'hA5, 8'hFF, 8'h07, 24, "R5 unknown cmd");
    send(8'hA5, 8'hFF, 8'h02, 24, "R5 poll");
    expect_ack(0, "R5 unknown command ignored");
    send(8'hA5, 8'hFF, 8'h01, 24, "R5 ping");
    send(8'h11, 8'hFF, 8'h01, 24, "R4 foreign ping");
    send(8'h11, 8'hFF, 8'h02, 24, "R4 foreign poll");
    send(8'hA5, 8'hFF, 8'h02, 24, "R4 poll");
    expect_ack(1, "R4 reply kept across foreign packets");
    expect_ack(0, "R8 idle after acknowledge");
    send(8'hA5, 8'hFF, 8'h01, 12, "R8 short ping");
    send(8'hA5, 8'hFF, 8'h02, 24, "R8 poll");
    expect_ack(0, "R8 short ping aborted");
    send(8'hA5, 8'hFF, 8'h01, 24, "R2 ping");
    send(8'hA5, 8'hFF, 8'h02, 20, "R8 short poll");
    send(8'hA5, 8'hFF, 8'h02, 32, "R8 long poll");
    send(8'hA5, 8'hFF, 8'h02, 24, "R2 poll");
    has_data = 0;
    expect_ack(1, "R8 aborts keep owed reply, R2 framing");
  endtask

  initial begin
    run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #600000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule